// File: doc/BRIEF.md
# Dual-Halfword Dot-Product Accumulator

This block keeps a small bank of wide signed accumulators and, on each strobed operation, folds in a two-term dot product built from packed operands. Each 32-bit operand carries two signed 16-bit halfwords. The two products are formed, summed, and then added to or subtracted from the selected accumulator, all within one clock.

Mode inputs choose how the work is done. The halfwords can be paired lane to lane or crosswise. The products can be plain integer products or Q15 fractional products, which are doubled and have their single unrepresentable case clamped. The final value can also be clamped to the signed 32-bit range. Each accumulator owns a sticky overflow flag that records clamping events. A separate load port writes an accumulator directly, a clear input resets all flags, and a combinational read port exposes any accumulator.

Top module: `dotacc_unit`

## Requirements
- R1: After synchronous active-low reset every accumulator reads zero and every overflow flag is 0.
- R2: In straight pairing (op_crossed=0) the low halfword of A (bits 15:0) is multiplied by the low halfword of B, and the high halfword of A (bits 31:16) by the high halfword of B. Both are signed 16x16 products, and both are added to the selected accumulator when op_subtract=0.
- R3: In crossed pairing (op_crossed=1) the low halfword of A is multiplied by the high halfword of B, and the high halfword of A by the low halfword of B.
- R4: With op_subtract=1 both products are subtracted from the selected accumulator instead of added.
- R5: With op_frac=1 each product is doubled (shifted left by one) before it is accumulated.
- R6: With op_frac=1, a product whose two halfwords are both 0x8000 is replaced by 0x7FFFFFFF, and the selected accumulator's flag is set.
- R7: With op_sat=1 the result is clamped once, after both products have been applied. A value above 0x7FFFFFFF becomes 0x7FFFFFFF, and a value below -2^31 becomes -2^31 sign-extended to 64 bits. Either clamp sets the flag of that accumulator. An intermediate excursion that the second product cancels leaves no trace.
- R8: With op_sat=0 the accumulator wraps modulo 2^64.
- R9: When ld_valid=1 the accumulator ld_sel takes ld_value at the clock edge. If an operation targets the same accumulator in the same cycle, the load wins and the operation has no effect.
- R10: Flags are sticky, and an operation can set only the flag of its own accumulator. A flag_clr cycle clears all flags, but a flag set in that same cycle survives the clear.
- R11: rd_value shows accumulator rd_sel combinationally, and ovf_flags bit i shows the flag of accumulator i.
- R12: While op_valid=0 and ld_valid=0, changes on the operand and mode inputs leave every accumulator and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Performs an operation this cycle |
| op_acc_sel | input | 2 | Target accumulator of the operation |
| op_a | input | 32 | First packed operand, two signed halfwords |
| op_b | input | 32 | Second packed operand, two signed halfwords |
| op_subtract | input | 1 | 1 subtracts the products, 0 adds them |
| op_crossed | input | 1 | 1 pairs halfwords crosswise |
| op_frac | input | 1 | 1 selects Q15 fractional products |
| op_sat | input | 1 | 1 clamps the result to the signed 32-bit range |
| ld_valid | input | 1 | Loads an accumulator directly |
| ld_sel | input | 2 | Accumulator to load |
| ld_value | input | 64 | Value to load |
| flag_clr | input | 1 | Clears all overflow flags |
| rd_sel | input | 2 | Accumulator to read out |
| rd_value | output | 64 | Contents of accumulator rd_sel |
| ovf_flags | output | 4 | Sticky overflow flag per accumulator |

## Verification
The bench builds the block with its default parameters: four accumulators, 16-bit halfwords and 64-bit accumulators. These are the values at which the 0x8000 corner, the 0x7FFFFFFF and -2^31 clamp edges, and the 64-bit wrap can be reached with exact hexadecimal operands. Accumulators are preloaded just below the clamp and wrap boundaries so that a single operation crosses them. One operand pair makes the first product overshoot and the second cancel it, which shows that saturation is applied once. Load-versus-operation collisions and set-versus-clear flag collisions are each driven in a single cycle.

// File: rtl/dotacc_pkg.sv
// Package: shared mode record for the dot-product accumulator.
// Assumes: the mode fields are sampled together with the operation strobe.
package dotacc_pkg;
    typedef struct packed {
        logic subtract;
        logic crossed;
        logic frac;
        logic sat;
    } dot_mode_t;
endpackage

// File: rtl/dotacc_lane_mul.sv
// Module: one signed halfword product, with optional Q15 doubling.
// Assumes: both inputs are two's complement. In fractional mode the only
// product that cannot be doubled into range (MIN x MIN) is clamped and flagged.
module dotacc_lane_mul #(
    parameter int HALF_W = 16
) (
    input  logic [HALF_W-1:0]   x,
    input  logic [HALF_W-1:0]   y,
    input  logic                frac,
    output logic [2*HALF_W-1:0] prod,
    output logic                corner
);
    localparam int PW = 2 * HALF_W;
    localparam logic [HALF_W-1:0] HMIN = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic [PW-1:0]     PMAX = {1'b0, {(PW-1){1'b1}}};

    logic signed [PW-1:0] full;

    // forms the raw product and applies the fractional adjustment
    always_comb begin
        full   = $signed({{HALF_W{x[HALF_W-1]}}, x}) * $signed({{HALF_W{y[HALF_W-1]}}, y});
        corner = frac && (x == HMIN) && (y == HMIN);
        if (corner)
            prod = PMAX;
        else if (frac)
            prod = {full[PW-2:0], 1'b0};
        else
            prod = full;
    end
endmodule

// File: rtl/dotacc_combine.sv
// Module: applies both products to an accumulator value, then saturates once.
// Assumes: products are signed PW-bit values. Without saturation the sum wraps
// at ACC_W bits.
module dotacc_combine #(
    parameter int HALF_W = 16,
    parameter int ACC_W  = 64
) (
    input  logic [ACC_W-1:0]    acc_in,
    input  logic [2*HALF_W-1:0] p0,
    input  logic [2*HALF_W-1:0] p1,
    input  logic                subtract,
    input  logic                sat,
    output logic [ACC_W-1:0]    acc_out,
    output logic                clamped
);
    localparam int PW = 2 * HALF_W;
    localparam logic [ACC_W-1:0] SMAX = {{(ACC_W-PW+1){1'b0}}, {(PW-1){1'b1}}};
    localparam logic [ACC_W-1:0] SMIN = ~SMAX;

    logic [ACC_W-1:0] e0, e1, sum;
    logic             too_high, too_low;

    // sign-extends, accumulates, then applies the single final clamp
    always_comb begin
        e0       = {{(ACC_W-PW){p0[PW-1]}}, p0};
        e1       = {{(ACC_W-PW){p1[PW-1]}}, p1};
        sum      = subtract ? (acc_in - e0 - e1) : (acc_in + e0 + e1);
        too_high = $signed(sum) > $signed(SMAX);
        too_low  = $signed(sum) < $signed(SMIN);
        clamped  = sat && (too_high || too_low);
        if (sat && too_high)
            acc_out = SMAX;
        else if (sat && too_low)
            acc_out = SMIN;
        else
            acc_out = sum;
    end
endmodule

// File: rtl/dotacc_bank.sv
// Module: accumulator registers and sticky flags.
// Assumes: a load and an update never hit the same entry in one cycle (the
// top resolves that). A flag set in a clear cycle survives the clear.
module dotacc_bank #(
    parameter int NUM_ACC = 4,
    parameter int ACC_W   = 64,
    parameter int SEL_W   = $clog2(NUM_ACC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            upd_en,
    input  logic [SEL_W-1:0]                upd_sel,
    input  logic [ACC_W-1:0]                upd_data,
    input  logic                            upd_flag,
    input  logic                            ld_en,
    input  logic [SEL_W-1:0]                ld_sel,
    input  logic [ACC_W-1:0]                ld_data,
    input  logic                            flag_clr,
    output logic [NUM_ACC-1:0][ACC_W-1:0]   acc_q,
    output logic [NUM_ACC-1:0]              flag_q
);
    for (genvar i = 0; i < NUM_ACC; i++) begin : g_entry
        logic hit_ld, hit_upd;
        assign hit_ld  = ld_en  && (ld_sel  == SEL_W'(i));
        assign hit_upd = upd_en && (upd_sel == SEL_W'(i));

        // holds one accumulator: reset, load or operation result
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_q[i] <= '0;
            else if (hit_ld)
                acc_q[i] <= ld_data;
            else if (hit_upd)
                acc_q[i] <= upd_data;
        end

        // holds one sticky flag: a set wins over a clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[i] <= 1'b0;
            else if (hit_upd && upd_flag)
                flag_q[i] <= 1'b1;
            else if (flag_clr)
                flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/dotacc_unit.sv
// Module: top of the dual-halfword dot-product accumulator.
// Assumes: an operation completes in the cycle its strobe is high. A load to
// the same accumulator in that cycle discards the operation.
module dotacc_unit #(
    parameter int NUM_ACC = 4,
    parameter int HALF_W  = 16,
    parameter int ACC_W   = 64,
    parameter int SEL_W   = $clog2(NUM_ACC),
    parameter int WORD_W  = 2 * HALF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [SEL_W-1:0]   op_acc_sel,
    input  logic [WORD_W-1:0]  op_a,
    input  logic [WORD_W-1:0]  op_b,
    input  logic               op_subtract,
    input  logic               op_crossed,
    input  logic               op_frac,
    input  logic               op_sat,
    input  logic               ld_valid,
    input  logic [SEL_W-1:0]   ld_sel,
    input  logic [ACC_W-1:0]   ld_value,
    input  logic               flag_clr,
    input  logic [SEL_W-1:0]   rd_sel,
    output logic [ACC_W-1:0]   rd_value,
    output logic [NUM_ACC-1:0] ovf_flags
);
    import dotacc_pkg::*;
    localparam int LANES = 2;

    dot_mode_t                        mode;
    logic [LANES-1:0][HALF_W-1:0]     a_half, b_half;
    logic [LANES-1:0][WORD_W-1:0]     lane_prod;
    logic [LANES-1:0]                 lane_corner;
    logic [NUM_ACC-1:0][ACC_W-1:0]    acc_q;
    logic [ACC_W-1:0]                 new_acc;
    logic                             clamped, op_go;

    // gathers the mode bits into one record
    assign mode = '{subtract: op_subtract, crossed: op_crossed, frac: op_frac, sat: op_sat};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        // picks the halfword pairing for this lane
        assign a_half[k] = op_a[k*HALF_W +: HALF_W];
        assign b_half[k] = mode.crossed ? op_b[(LANES-1-k)*HALF_W +: HALF_W]
                                        : op_b[k*HALF_W +: HALF_W];
        dotacc_lane_mul #(.HALF_W(HALF_W)) u_mul (
            .x      (a_half[k]),
            .y      (b_half[k]),
            .frac   (mode.frac),
            .prod   (lane_prod[k]),
            .corner (lane_corner[k])
        );
    end

    dotacc_combine #(.HALF_W(HALF_W), .ACC_W(ACC_W)) u_comb (
        .acc_in   (acc_q[op_acc_sel]),
        .p0       (lane_prod[0]),
        .p1       (lane_prod[1]),
        .subtract (mode.subtract),
        .sat      (mode.sat),
        .acc_out  (new_acc),
        .clamped  (clamped)
    );

    // drops an operation that collides with a load to the same entry
    assign op_go = op_valid && !(ld_valid && (ld_sel == op_acc_sel));

    dotacc_bank #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (op_go),
        .upd_sel  (op_acc_sel),
        .upd_data (new_acc),
        .upd_flag (clamped || (|lane_corner)),
        .ld_en    (ld_valid),
        .ld_sel   (ld_sel),
        .ld_data  (ld_value),
        .flag_clr (flag_clr),
        .acc_q    (acc_q),
        .flag_q   (ovf_flags)
    );

    // exposes the requested accumulator
    assign rd_value = acc_q[rd_sel];
endmodule

// File: rtl/dotacc_chk.sv
// Module: temporal checks on the accumulator's ports, bound to the top.
module dotacc_chk #(
    parameter int NUM_ACC = 4,
    parameter int HALF_W  = 16,
    parameter int ACC_W   = 64,
    parameter int SEL_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               op_valid,
    input logic [SEL_W-1:0]   op_acc_sel,
    input logic               op_frac,
    input logic               op_sat,
    input logic               ld_valid,
    input logic [SEL_W-1:0]   ld_sel,
    input logic [ACC_W-1:0]   ld_value,
    input logic               flag_clr,
    input logic [SEL_W-1:0]   rd_sel,
    input logic [ACC_W-1:0]   rd_value,
    input logic [NUM_ACC-1:0] ovf_flags
);
    localparam int PW = 2 * HALF_W;

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_clr |=> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

    // R10
    flag_own_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> ((ovf_flags & ~$past(ovf_flags) & ~(NUM_ACC'(1) << $past(op_acc_sel))) == '0));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !op_valid) |=> (ovf_flags == '0));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid && !ld_valid) ##1 (rd_sel == $past(rd_sel)) |-> (rd_value == $past(rd_value)));

    // R9
    load_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid ##1 (rd_sel == $past(ld_sel)) |-> (rd_value == $past(ld_value)));

    // R7
    sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sat && !(ld_valid && ld_sel == op_acc_sel)) ##1 (rd_sel == $past(op_acc_sel))
        |-> ((rd_value[ACC_W-1:PW-1] == '0) || (rd_value[ACC_W-1:PW-1] == '1)));

    // R6
    int_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_frac && !op_sat) |=> ((ovf_flags & ~$past(ovf_flags)) == '0));
endmodule

bind dotacc_unit dotacc_chk #(
    .NUM_ACC (NUM_ACC),
    .HALF_W  (HALF_W),
    .ACC_W   (ACC_W),
    .SEL_W   (SEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_acc_sel (op_acc_sel),
    .op_frac    (op_frac),
    .op_sat     (op_sat),
    .ld_valid   (ld_valid),
    .ld_sel     (ld_sel),
    .ld_value   (ld_value),
    .flag_clr   (flag_clr),
    .rd_sel     (rd_sel),
    .rd_value   (rd_value),
    .ovf_flags  (ovf_flags)
);

// File: tb/tb_dotacc_unit.sv
module tb_dotacc_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_acc_sel = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        op_subtract = 1'b0, op_crossed = 1'b0, op_frac = 1'b0, op_sat = 1'b0;
    logic        ld_valid = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [63:0] ld_value = '0;
    logic        flag_clr = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [63:0] rd_value;
    logic [3:0]  ovf_flags;

    int total = 0, bad = 0;
    bit finished = 1'b0;
    logic [63:0] exp_acc [4];
    logic [3:0]  exp_flags;

    always #(CLK_PERIOD/2) clk = ~clk;

    dotacc_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_acc_sel(op_acc_sel),
        .op_a(op_a), .op_b(op_b), .op_subtract(op_subtract), .op_crossed(op_crossed),
        .op_frac(op_frac), .op_sat(op_sat), .ld_valid(ld_valid), .ld_sel(ld_sel),
        .ld_value(ld_value), .flag_clr(flag_clr), .rd_sel(rd_sel),
        .rd_value(rd_value), .ovf_flags(ovf_flags)
    );

    // Expected result of one operation, worked out from the requirements.
    task automatic model_op(input logic [1:0] s, input logic [31:0] a, input logic [31:0] b,
                            input bit sub, input bit cr, input bit fr, input bit sat,
                            inout logic [3:0] nf);
        longint acc;
        acc = longint'(exp_acc[s]);
        for (int k = 0; k < 2; k++) begin
            logic [15:0] ha, hb;
            longint p;
            ha = (k == 0) ? a[15:0] : a[31:16];
            hb = cr ? ((k == 0) ? b[31:16] : b[15:0]) : ((k == 0) ? b[15:0] : b[31:16]);
            p = longint'(shortint'(ha)) * longint'(shortint'(hb));
            if (fr) begin
                if (ha == 16'h8000 && hb == 16'h8000) begin
                    p = 64'h7FFFFFFF;
                    nf[s] = 1'b1;
                end else p = p * 2;
            end
            acc = sub ? acc - p : acc + p;
        end
        if (sat && acc > 64'sh7FFFFFFF) begin
            acc = 64'sh7FFFFFFF; nf[s] = 1'b1;
        end else if (sat && acc < -64'sh80000000) begin
            acc = -64'sh80000000; nf[s] = 1'b1;
        end
        exp_acc[s] = 64'(acc);
    endtask

    // Drives one cycle of stimulus and updates the expectation.
    task automatic cycle(input bit ov, input logic [1:0] s, input logic [31:0] a, input logic [31:0] b,
                         input bit sub, input bit cr, input bit fr, input bit sat,
                         input bit lv, input logic [1:0] ls, input logic [63:0] ld, input bit clr);
        logic [3:0] nf;
        @(negedge clk);
        op_valid = ov; op_acc_sel = s; op_a = a; op_b = b;
        op_subtract = sub; op_crossed = cr; op_frac = fr; op_sat = sat;
        ld_valid = lv; ld_sel = ls; ld_value = ld; flag_clr = clr;
        nf = clr ? 4'b0 : exp_flags;
        if (ov && !(lv && ls == s)) model_op(s, a, b, sub, cr, fr, sat, nf);
        if (lv) exp_acc[ls] = ld;
        exp_flags = nf;
        @(negedge clk);
        op_valid = 1'b0; ld_valid = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic load(input logic [1:0] s, input logic [63:0] v);
        cycle(1'b0, 2'd0, 32'h0, 32'h0, 0, 0, 0, 0, 1'b1, s, v, 1'b0);
    endtask

    task automatic op(input logic [1:0] s, input logic [31:0] a, input logic [31:0] b,
                      input bit sub, input bit cr, input bit fr, input bit sat);
        cycle(1'b1, s, a, b, sub, cr, fr, sat, 1'b0, 2'd0, 64'h0, 1'b0);
    endtask

    // Reads every accumulator through the read port and compares with the flags.
    task automatic check_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            rd_sel = 2'(i);
            #1;
            total++;
            if (rd_value !== exp_acc[i]) begin
                bad++;
                $display("FAIL %s acc%0d: got %h expected %h", tag, i, rd_value, exp_acc[i]);
            end
        end
        total++;
        if (ovf_flags !== exp_flags) begin
            bad++;
            $display("FAIL %s flags: got %b expected %b", tag, ovf_flags, exp_flags);
        end
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) exp_acc[i] = '0;
        exp_flags = '0;
        check_all("R1 reset, R11 read port");
    endtask

    task automatic t_straight;
        load(2'd1, 64'd100);
        op(2'd1, 32'h0003_FFFE, 32'h0005_0007, 0, 0, 0, 0);
        check_all("R2 straight add");
        op(2'd1, 32'h7FFF_8001, 32'h7FFF_7FFF, 0, 0, 0, 0);
        check_all("R2 straight large");
    endtask

    task automatic t_crossed;
        load(2'd2, 64'd0);
        op(2'd2, 32'h0003_FFFE, 32'h0005_0007, 0, 1, 0, 0);
        check_all("R3 crossed add");
    endtask

    task automatic t_subtract;
        op(2'd1, 32'h0012_0034, 32'hFFF0_0100, 1, 0, 0, 0);
        check_all("R4 straight subtract");
        op(2'd2, 32'h0012_0034, 32'hFFF0_0100, 1, 1, 0, 0);
        check_all("R4 crossed subtract");
    endtask

    task automatic t_frac;
        load(2'd0, 64'd0);
        op(2'd0, 32'h4000_2000, 32'h0004_0003, 0, 0, 1, 0);
        check_all("R5 fractional doubling");
    endtask

    task automatic t_corner;
        load(2'd3, 64'd0);
        op(2'd3, 32'h8000_8000, 32'h8000_8000, 0, 0, 1, 0);
        check_all("R6 Q15 corner clamp and flag");
    endtask

    task automatic t_sat;
        cycle(1'b0, 2'd0, 0, 0, 0, 0, 0, 0, 1'b0, 2'd0, 64'h0, 1'b1);
        load(2'd3, 64'h0000_0000_7FFF_FFF0);
        op(2'd3, 32'h0010_0010, 32'hFFF0_0010, 0, 0, 0, 1);
        check_all("R7 single final clamp, no flag");
        load(2'd0, 64'h0000_0000_7FFF_FF00);
        op(2'd0, 32'h0000_0100, 32'h0000_0100, 0, 0, 0, 1);
        check_all("R7 clamp high");
        load(2'd1, 64'hFFFF_FFFF_8000_0010);
        op(2'd1, 32'h0000_0100, 32'h0000_0100, 1, 0, 0, 1);
        check_all("R7 clamp low");
    endtask

    task automatic t_wrap;
        load(2'd2, 64'h7FFF_FFFF_FFFF_FFFF);
        op(2'd2, 32'h0000_0001, 32'h0000_0001, 0, 0, 0, 0);
        check_all("R8 wrap modulo 2^64");
    endtask

    task automatic t_load_priority;
        cycle(1'b1, 2'd3, 32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0, 1'b1, 2'd3, 64'h1234, 1'b0);
        check_all("R9 load wins same accumulator");
        cycle(1'b1, 2'd0, 32'h0001_0001, 32'h0001_0001, 0, 0, 0, 0, 1'b1, 2'd3, 64'h55, 1'b0);
        check_all("R9 load and op to different accumulators");
    endtask

    task automatic t_flags;
        cycle(1'b1, 2'd2, 32'h8000_0000, 32'h8000_0000, 0, 0, 1, 0, 1'b0, 2'd0, 64'h0, 1'b1);
        check_all("R10 set survives clear");
        cycle(1'b0, 2'd0, 0, 0, 0, 0, 0, 0, 1'b0, 2'd0, 64'h0, 1'b1);
        check_all("R10 synchronous clear");
    endtask

    task automatic t_idle;
        @(negedge clk);
        op_a = 32'h8000_8000; op_b = 32'h8000_8000; op_frac = 1'b1; op_sat = 1'b1;
        op_acc_sel = 2'd1; ld_value = 64'hDEAD;
        repeat (3) @(negedge clk);
        check_all("R12 idle inputs ignored");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_straight();
        t_crossed();
        t_subtract();
        t_frac();
        t_corner();
        t_sat();
        t_wrap();
        t_load_priority();
        t_flags();
        t_idle();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule